// File: doc/BRIEF.md
# Brown-out reset control unit

This block is the digital side of a two-channel supply monitor. It takes the outputs of two analog brown-out comparators, which are asynchronous to the system clock. It keeps a write-protected control register that sets the threshold of the adjustable comparator. The same register switches the fixed comparator on or off, keeps that comparator running in power-down, and chooses which brown-out events cause a system reset. A reset-status register holds two sticky brown-out flags, which software clears by writing 1.

When a comparator reports low supply and its flag goes from 0 to 1, the block asserts a reset request. It does this only when that channel's reset enable is on. The request stays high for a fixed number of clock cycles. The reset it causes does not clear the flags, so after restart the firmware can read which channel caused it. The block's own reset input (`rst_n`) does clear the flags.

Writes to the control register are protected. First, 0x55 and then 0xAA must be written to a key address on back-to-back clock cycles. Only the next write after that may change the control register. Reads of every register are always allowed.

Register addresses:

| Register | Address |
|---|---|
| Control | 0 |
| Status | 1 |
| Key | 2 |

Control register fields:

| Bit | Field |
|---|---|
| 0 | Threshold select |
| 2 | Channel-0 reset enable |
| 3 | Channel-1 reset enable |
| 6 | Channel-1 enable |
| 7 | Channel-1 active in power-down |

Status register fields:

| Bit | Field |
|---|---|
| 1 | Channel-0 flag |
| 2 | Channel-1 flag |

Top module: `supply_guard`

## Requirements
- R1: After `rst_n` is low, the control register reads 0x40 with bit 0 replaced by `nv_level`. The status register reads 0x00, `rst_req` is 0, and `lvl_sel` equals `nv_level`.
- R2: A write to the control register that does not follow a completed unlock leaves the register unchanged.
- R3: Unlocking means writing 0x55 to the key address and then 0xAA on the very next clock cycle. The next write after that is accepted if it goes to the control register. The unlock is used up by that one write, so a later write without a new unlock is ignored.
- R4: Any of the following cancels an unlock, and the next control write is then ignored:
  - a cycle without a key write between 0x55 and 0xAA;
  - a wrong key value;
  - any other write after 0xAA.
- R5: Control bits 5, 4 and 1 always read as 0, whatever is written to them.
- R6: Each comparator input passes through a two-flop synchronizer. A low-supply level applied before clock edge k sets its flag at edge k+2, and the flag stays set after the input returns to normal.
- R7: Writing a status byte with bit 1 (or bit 2) set clears flag 0 (or flag 1). Writing 0 to a flag bit has no effect. If a clear and a hardware set meet in the same cycle, the flag stays 1.
- R8: When a flag goes from 0 to 1 and that channel's reset enable (control bit 2 for channel 0, bit 3 for channel 1) is 1, `rst_req` rises in the same cycle as the flag. It stays high for exactly 16 cycles, and the flag is still set afterwards.
- R9: When the channel's reset enable is 0, the flag still sets but `rst_req` stays 0.
- R10: While channel-1 enable (control bit 6) is 0, the channel-1 comparator cannot set flag 1 or cause a reset, and `det1_power` is 0.
- R11: In power-down (`pd_mode` = 1), channel 1 is ignored and `det1_power` is 0 unless control bit 7 is 1. When bit 7 is 1, channel 1 keeps setting its flag in power-down.
- R12: `lvl_sel` always equals control bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 2 | Register address (0 control, 1 status, 2 key) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pd_mode | input | 1 | Chip is in power-down |
| nv_level | input | 1 | Nonvolatile option bit giving the reset value of the threshold select |
| det0_low | input | 1 | Asynchronous: supply below the channel-0 threshold |
| det1_low | input | 1 | Asynchronous: supply below the channel-1 fixed threshold |
| lvl_sel | output | 1 | Threshold select to the channel-0 and power-on comparators |
| det1_power | output | 1 | Enable for the channel-1 comparator |
| rst_req | output | 1 | Stretched system reset request |

## Verification
The flag and reset path is tested with four kinds of comparator input:
- A short low pulse. This shows the two-cycle synchronizer delay, the 16-cycle stretch of `rst_req`, and that the flag stays set after the pulse.
- A level held low during a write-1 clear. This separates set-wins from clear-wins.
- A pulse with the reset enable off. This separates setting the flag from requesting a reset.
- Channel-1 pulses under each combination of enable and power-down keep-alive. These tell the masking paths apart.

The unlock is tested with a correct sequence, with the gap, wrong-value and other-write forms of cancellation, and with a write that tries to reuse an unlock. The reset value is checked with both settings of the option bit.

// File: rtl/supply_guard_pkg.sv
// Package: shared register map, field positions, key values and unlock
// states for the brown-out reset control unit.
package supply_guard_pkg;
    localparam int DATA_W = 8;

    // Register addresses on the block's bus
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_STAT = 1;
    localparam int ADDR_KEY  = 2;

    // Control register field positions
    localparam int CB_LVL   = 0;
    localparam int CB_RE0   = 2;
    localparam int CB_RE1   = 3;
    localparam int CB_EN1   = 6;
    localparam int CB_KEEP1 = 7;

    // Status register field positions
    localparam int SB_FLAG0 = 1;
    localparam int SB_FLAG1 = 2;

    // Reset value and writable-bit mask of the control register
    localparam logic [DATA_W-1:0] CTRL_RST   = 8'h40;
    localparam logic [DATA_W-1:0] CTRL_WMASK = 8'hCD;

    // Unlock key bytes
    localparam logic [DATA_W-1:0] KEY_FIRST  = 8'h55;
    localparam logic [DATA_W-1:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        UL_IDLE = 2'd0,
        UL_HALF = 2'd1,
        UL_OPEN = 2'd2
    } unlock_state_t;
endpackage

// File: rtl/sg_sync.sv
// Module: sg_sync
// Multi-flop synchronizer for one asynchronous level input.
// Assumes: STAGES >= 2; the input is a slow level (a comparator output),
// so no pulse-capture logic is needed. Output resets to 0.
module sg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sg_unlock.sv
// Module: sg_unlock
// Key-sequence tracker for protected writes. The first key byte, then the
// second key byte on the next cycle, opens the gate. The gate closes on
// any following write, whatever its address.
// Assumes: at most one bus write per cycle; wr_key implies wr_any.
module sg_unlock
    import supply_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_any,
    input  logic              wr_key,
    input  logic [DATA_W-1:0] wdata,
    output logic              armed
);
    unlock_state_t state_q, state_d;
    logic first_hit, second_hit;

    assign first_hit  = wr_key && (wdata == KEY_FIRST);
    assign second_hit = wr_key && (wdata == KEY_SECOND);

    // Next-state logic for the key sequence
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UL_IDLE: if (first_hit) state_d = UL_HALF;
            UL_HALF: begin
                if (second_hit)     state_d = UL_OPEN;
                else if (first_hit) state_d = UL_HALF;
                else                state_d = UL_IDLE;
            end
            UL_OPEN: if (wr_any) state_d = first_hit ? UL_HALF : UL_IDLE;
            default: state_d = UL_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= UL_IDLE;
        else        state_q <= state_d;
    end

    assign armed = (state_q == UL_OPEN);

    // R3: the gate opens only right after first byte then second byte
    a_r3_open_after_keys: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(state_q == UL_HALF && wr_key && wdata == KEY_SECOND));
    // R4: any write while open consumes or cancels the unlock
    a_r4_single_use: assert property (@(posedge clk) disable iff (!rst_n)
        armed && wr_any |=> !armed);
endmodule

// File: rtl/sg_stretch.sv
// Module: sg_stretch
// Stretches a one-cycle trigger into a request exactly LEN cycles long,
// starting in the cycle after the trigger edge. A new trigger reloads it.
// Assumes: LEN >= 1.
module sg_stretch #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic active
);
    localparam int CW = $clog2(LEN + 1);
    logic [CW-1:0] cnt_q;

    // Load on trigger, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (trig)        cnt_q <= CW'(LEN);
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign active = (cnt_q != '0);

    // R8: counter never exceeds the stretch length
    a_r8_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LEN));
    // R8: a trigger always yields an active request next cycle
    a_r8_trig_starts: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> active);
endmodule

// File: rtl/supply_guard.sv
// Module: supply_guard (top)
// Brown-out reset control: protected control register, sticky W1C
// brown-out flags, masking of channel 1 by enable and power-down, and a
// stretched reset request on a flag's 0->1 edge with its reset enabled.
// Assumes: nv_level is stable while rst_n is low; the comparator inputs
// are asynchronous levels; rst_req is not fed back to rst_n of this block.
module supply_guard
    import supply_guard_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2,
    parameter int REQ_CYCLES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pd_mode,
    input  logic              nv_level,
    input  logic              det0_low,
    input  logic              det1_low,
    output logic              lvl_sel,
    output logic              det1_power,
    output logic              rst_req
);
    localparam int NDET = 2;

    logic [DATA_W-1:0] ctrl_q;
    logic              flag0_q, flag1_q;
    logic [NDET-1:0]   det_raw, det_sync;
    logic              sel_ctrl, sel_stat, sel_key;
    logic              armed, ctrl_wr, stat_wr;
    logic              clr0, clr1, set0, set1, det1_live, trig;

    assign sel_ctrl = (bus_addr == ADDR_W'(ADDR_CTRL));
    assign sel_stat = (bus_addr == ADDR_W'(ADDR_STAT));
    assign sel_key  = (bus_addr == ADDR_W'(ADDR_KEY));

    // Synchronizers, one per comparator channel
    assign det_raw = {det1_low, det0_low};
    for (genvar g = 0; g < NDET; g++) begin : g_sync
        sg_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .d(det_raw[g]), .q(det_sync[g])
        );
    end

    sg_unlock u_unlock (
        .clk(clk), .rst_n(rst_n),
        .wr_any(bus_we), .wr_key(bus_we && sel_key),
        .wdata(bus_wdata), .armed(armed)
    );

    assign ctrl_wr = bus_we && sel_ctrl && armed;
    assign stat_wr = bus_we && sel_stat;

    // Control register: reset value with level select taken from the option bit
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= CTRL_RST | {{(DATA_W-1){1'b0}}, nv_level};
        else if (ctrl_wr) ctrl_q <= bus_wdata & CTRL_WMASK;
    end

    assign det1_live = ctrl_q[CB_EN1] && (!pd_mode || ctrl_q[CB_KEEP1]);
    assign set0 = det_sync[0];
    assign set1 = det_sync[1] && det1_live;
    assign clr0 = stat_wr && bus_wdata[SB_FLAG0];
    assign clr1 = stat_wr && bus_wdata[SB_FLAG1];

    // Sticky flags: hardware set has priority over software clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag0_q <= 1'b0;
            flag1_q <= 1'b0;
        end else begin
            flag0_q <= set0 || (flag0_q && !clr0);
            flag1_q <= set1 || (flag1_q && !clr1);
        end
    end

    // Reset trigger: a flag's 0->1 edge with its reset enable on
    assign trig = (set0 && !flag0_q && ctrl_q[CB_RE0]) ||
                  (set1 && !flag1_q && ctrl_q[CB_RE1]);

    sg_stretch #(.LEN(REQ_CYCLES)) u_stretch (
        .clk(clk), .rst_n(rst_n), .trig(trig), .active(rst_req)
    );

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl)      bus_rdata = ctrl_q;
        else if (sel_stat) begin
            bus_rdata[SB_FLAG0] = flag0_q;
            bus_rdata[SB_FLAG1] = flag1_q;
        end
    end

    assign lvl_sel    = ctrl_q[CB_LVL];
    assign det1_power = det1_live;

    // R2: control register changes only on an unlocked control write
    a_r2_ctrl_protected: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q) |-> $past(armed && bus_we && sel_ctrl));
    // R5: reserved control bits stay zero
    a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTRL_WMASK) == '0);
    // R7: a set flag without a clear write stays set
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag0_q && !(bus_we && sel_stat && bus_wdata[SB_FLAG0]) |=> flag0_q);
    // R8: flag 0 rising with its reset enable raises the request
    a_r8_req_on_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag0_q) && $past(ctrl_q[CB_RE0]) |-> rst_req);
    // R9: a request only starts together with a flag edge
    a_r9_req_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> ($rose(flag0_q) || $rose(flag1_q)));
    // R10: flag 1 can only rise while channel 1 is enabled
    a_r10_det1_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag1_q) |-> $past(ctrl_q[CB_EN1]));
    // R11: flag 1 cannot rise in power-down without keep-alive
    a_r11_pd_mask: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag1_q) |-> $past(!pd_mode || ctrl_q[CB_KEEP1]));
endmodule

// File: tb/supply_guard_tb.sv
// Directed bench for supply_guard: one task per scenario, each self-checking.
module supply_guard_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       pd_mode = 1'b0, nv_level = 1'b1;
    logic       det0_low = 1'b0, det1_low = 1'b0;
    logic       lvl_sel, det1_power, rst_req;
    int         checks = 0, failures = 0;

    localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_KEY = 2'd2;

    always #10 clk = ~clk;

    supply_guard u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pd_mode(pd_mode),
        .nv_level(nv_level), .det0_low(det0_low), .det1_low(det1_low),
        .lvl_sel(lvl_sel), .det1_power(det1_power), .rst_req(rst_req)
    );

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%02h exp=%02h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic set_ctrl(logic [7:0] v);
        wr(A_KEY, 8'h55); wr(A_KEY, 8'hAA); wr(A_CTRL, v);
    endtask

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Counts request-high cycles over the next n cycles
    task automatic count_req(int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin @(negedge clk); if (rst_req) hi++; end
    endtask

    task automatic t_reset(logic nv);
        logic [7:0] d;
        nv_level = nv; rst_n = 1'b0; cycles(3); rst_n = 1'b1; cycles(1);
        rd(A_CTRL, d); chk("R1 ctrl reset", d, 8'h40 | {7'd0, nv});
        rd(A_STAT, d); chk("R1 status reset", d, 8'h00);
        chk("R1 rst_req reset", {7'd0, rst_req}, 8'h00);
        chk("R1 lvl_sel reset", {7'd0, lvl_sel}, {7'd0, nv});
    endtask

    task automatic t_protect;
        logic [7:0] d;
        wr(A_CTRL, 8'hCD); rd(A_CTRL, d); chk("R2 unprotected write ignored", d, 8'h41);
    endtask

    task automatic t_unlock;
        logic [7:0] d;
        set_ctrl(8'hFF); rd(A_CTRL, d); chk("R3/R5 unlocked write, reserved zero", d, 8'hCD);
        chk("R12 lvl_sel follows bit0", {7'd0, lvl_sel}, 8'h01);
        wr(A_CTRL, 8'h00); rd(A_CTRL, d); chk("R3 unlock used once", d, 8'hCD);
        set_ctrl(8'h40); rd(A_CTRL, d); chk("R3 second unlock", d, 8'h40);
        chk("R12 lvl_sel cleared", {7'd0, lvl_sel}, 8'h00);
    endtask

    task automatic t_cancel;
        logic [7:0] d;
        wr(A_KEY, 8'h55); cycles(1); wr(A_KEY, 8'hAA); wr(A_CTRL, 8'h45);
        rd(A_CTRL, d); chk("R4 gap cancels", d, 8'h40);
        wr(A_KEY, 8'h55); wr(A_KEY, 8'hA5); wr(A_CTRL, 8'h45);
        rd(A_CTRL, d); chk("R4 wrong key cancels", d, 8'h40);
        wr(A_KEY, 8'h55); wr(A_KEY, 8'hAA); wr(A_STAT, 8'h00); wr(A_CTRL, 8'h45);
        rd(A_CTRL, d); chk("R4 other write cancels", d, 8'h40);
    endtask

    task automatic t_det0;
        logic [7:0] d; int hi;
        set_ctrl(8'h44);
        det0_low = 1'b1; cycles(2);
        rd(A_STAT, d); chk("R6 no flag before two sync flops", d, 8'h00);
        chk("R8 no request before flag", {7'd0, rst_req}, 8'h00);
        det0_low = 1'b0; cycles(1);
        rd(A_STAT, d); chk("R6 flag0 at third edge", d, 8'h02);
        chk("R8 request with flag", {7'd0, rst_req}, 8'h01);
        count_req(20, hi); chk("R8 request length 16", 8'(hi + 1), 8'd16);
        rd(A_STAT, d); chk("R8 flag survives request", d, 8'h02);
        wr(A_STAT, 8'h00); rd(A_STAT, d); chk("R7 write 0 no effect", d, 8'h02);
        wr(A_STAT, 8'h02); rd(A_STAT, d); chk("R7 write 1 clears", d, 8'h00);
    endtask

    task automatic t_set_wins;
        logic [7:0] d;
        det0_low = 1'b1; cycles(4);
        wr(A_STAT, 8'h02); rd(A_STAT, d); chk("R7 set wins over clear", d, 8'h02);
        det0_low = 1'b0; cycles(20);
        wr(A_STAT, 8'h02); rd(A_STAT, d); chk("R7 clear after release", d, 8'h00);
    endtask

    task automatic t_no_reset;
        logic [7:0] d; int hi;
        set_ctrl(8'h40);
        det0_low = 1'b1; cycles(3); det0_low = 1'b0;
        count_req(20, hi); chk("R9 no request without enable", 8'(hi), 8'd0);
        rd(A_STAT, d); chk("R9 flag still set", d, 8'h02);
        wr(A_STAT, 8'h02);
    endtask

    task automatic t_det1_off;
        logic [7:0] d; int hi;
        set_ctrl(8'h08);
        chk("R10 det1_power off", {7'd0, det1_power}, 8'h00);
        det1_low = 1'b1; count_req(6, hi); det1_low = 1'b0; cycles(4);
        rd(A_STAT, d); chk("R10 disabled channel no flag", d, 8'h00);
        chk("R10 disabled channel no request", 8'(hi), 8'd0);
    endtask

    task automatic t_pd;
        logic [7:0] d;
        set_ctrl(8'h48); pd_mode = 1'b1; #1;
        chk("R11 det1_power off in pd", {7'd0, det1_power}, 8'h00);
        det1_low = 1'b1; cycles(6);
        rd(A_STAT, d); chk("R11 pd masks channel 1", d, 8'h00);
        pd_mode = 1'b0; cycles(1);
        rd(A_STAT, d); chk("R11 flag1 after leaving pd", d, 8'h04);
        chk("R8 channel 1 request", {7'd0, rst_req}, 8'h01);
        det1_low = 1'b0; cycles(20); wr(A_STAT, 8'h04);
        rd(A_STAT, d); chk("R7 clear flag1", d, 8'h00);
        set_ctrl(8'hC8); pd_mode = 1'b1; #1;
        chk("R11 det1_power kept in pd", {7'd0, det1_power}, 8'h01);
        det1_low = 1'b1; cycles(4);
        rd(A_STAT, d); chk("R11 keep-alive sets flag1 in pd", d, 8'h04);
        det1_low = 1'b0; pd_mode = 1'b0; cycles(20); wr(A_STAT, 8'h04);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset(1'b1);
        t_protect();
        t_unlock();
        t_cancel();
        t_det0();
        t_set_wins();
        t_no_reset();
        t_det1_off();
        t_pd();
        t_reset(1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule